// File: doc/BRIEF.md
# Quad-Line Serial Flash Read Sequencer

This block turns a single read request (a 24-bit byte address and a byte count) into one complete read frame toward a serial NOR flash that answers on four data lines. It owns the chip select, generates the serial clock from the system clock, and drives and releases the four data pads. The frame is always the same shape: an 8-bit command on one line, the address on all four lines, a fixed run of turnaround clocks during which the block drives nothing, and then the data, one nibble per clock.

Each received byte leaves the block on a valid/ready stream. When the consumer stalls, the block holds the serial clock low instead of buffering, so no byte is ever dropped. The end of every request is marked by a one-cycle done pulse. The request port reopens only after chip select has been high for at least one full serial-clock period and the output stream is empty. A request with a byte count of zero finishes at once and leaves the flash untouched.

The serial clock half-period, in system clocks, and the width of the byte count are parameters. Clock mode 0 is used: the clock idles low, outputs change after a falling edge, and inputs are sampled at the rising edge.

Top module: `qspi_quad_reader`

## Requirements
- R1: After reset cs_n is 1, sck is 0, io_oe is 0000, rd_valid is 0, done is 0 and req_ready is 1.
- R2: The first 8 rising sck edges of a frame carry the command byte 0xEB on io_out[0], most significant bit first, with io_oe = 0001.
- R3: Rising edges 8 to 13 carry the 24-bit address on all four lines, most significant nibble first, with io_out[3] holding the highest bit of each nibble and io_oe = 1111.
- R4: From rising edge 14 to the end of the frame io_oe is 0000: 6 turnaround clocks, then the data clocks.
- R5: From rising edge 20 on, the block takes io_in on each rising edge, high nibble first with io_in[3] as the top bit, and delivers req_len bytes for the ascending addresses in order.
- R6: sck idles low with a high phase of exactly SCK_HALF system clocks, and io_out/io_oe never change while sck is high.
- R7: A frame has exactly 20 + 2*req_len rising sck edges while cs_n is low, and sck is low whenever cs_n changes.
- R8: done pulses once when cs_n returns high, and cs_n stays high for at least 2*SCK_HALF system clocks before the next frame.
- R9: A request with req_len = 0 raises done in the next cycle and never lowers cs_n.
- R10: While rd_valid is 1 and rd_ready is 0, rd_data and rd_valid hold and sck does not rise, so no byte is lost under any stall pattern.
- R11: req_ready is 0 while cs_n is low and while a byte is still waiting on the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values for the four data pads |
| io_oe | output | 4 | Per-pad output enable |
| io_in | input | 4 | Values read from the four data pads |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench sweeps every byte count from zero to the largest the small configuration allows. It does this under three consumer patterns: always ready, ready on alternate cycles, and long pseudo-random stalls. Always-ready shows the frame length and byte order. The stall patterns separate a sequencer that freezes sck correctly from one that overwrites or drops a byte. A bench flash model captures the command and address from the pads and answers from an arithmetic memory image keyed by the address it actually received, so a wrong address, a nibble swap and an off-by-one clock count each give a different mismatch. Addresses near the top of the 24-bit space and back-to-back requests exercise the wrap and the chip-select gap.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  localparam logic [7:0] QRD_OPCODE     = 8'hEB;
  localparam int         QRD_CMD_CLKS   = 8;
  localparam int         QRD_ADDR_CLKS  = 6;
  localparam int         QRD_DUMMY_CLKS = 6;
  localparam int         QRD_ADDR_START = QRD_CMD_CLKS;
  localparam int         QRD_DUMMY_START = QRD_ADDR_START + QRD_ADDR_CLKS;
  localparam int         QRD_DATA_START = QRD_DUMMY_START + QRD_DUMMY_CLKS;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_GAP
  } qrd_state_e;

  typedef struct packed {
    logic [3:0] oe;
    logic [3:0] dout;
  } qrd_pad_t;

  // Number of rising sck edges in a frame carrying nbytes of data.
  function automatic int unsigned frame_clocks(input int unsigned nbytes);
    return QRD_DATA_START + 2 * nbytes;
  endfunction

  function automatic int unsigned last_clock(input int unsigned nbytes);
    return frame_clocks(nbytes) - 1;
  endfunction

  // Pad drive presented before rising edge number k of the frame.
  function automatic qrd_pad_t pad_for_clock(input int unsigned k,
                                             input logic [23:0] addr);
    qrd_pad_t p;
    p.oe   = 4'b0000;
    p.dout = 4'b0000;
    if (k < QRD_ADDR_START) begin
      p.oe   = 4'b0001;
      p.dout = {3'b000, QRD_OPCODE[3'(7 - k)]};
    end else if (k < QRD_DUMMY_START) begin
      p.oe   = 4'b1111;
      p.dout = 4'(addr >> (4 * (QRD_DUMMY_START - 1 - k)));
    end
    return p;
  endfunction

endpackage

// File: rtl/qrd_sck_gen.sv
module qrd_sck_gen #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold_low,
  output logic sck,
  output logic rise_ev,
  output logic fall_ev
);

  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end  = (cnt == CW'(SCK_HALF - 1));
  assign rise_ev = run && at_end && !sck && !hold_low;
  assign fall_ev = run && at_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (at_end) begin
      if (rise_ev) begin
        sck <= 1'b1;
        cnt <= '0;
      end else if (fall_ev) begin
        sck <= 1'b0;
        cnt <= '0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the clock idles low whenever no frame is running
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);

  // R10: a held-low request keeps the clock low
  assert_hold_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_low && !sck) |=> !sck);

endmodule

// File: rtl/qrd_byte_pack.sv
module qrd_byte_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_nib,
  input  logic       low_half,
  input  logic [3:0] nib,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_valid
);

  logic [3:0] hi_q;
  logic       byte_ev;

  assign byte_ev = take_nib && low_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 4'h0;
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      if (take_nib && !low_half) hi_q <= nib;
      if (byte_ev) begin
        rd_data  <= {hi_q, nib};
        rd_valid <= 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  // R10: a waiting byte is neither lost nor changed
  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R10: no new byte completes on top of a stalled one
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ev |-> !(rd_valid && !rd_ready));

endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader #(
  parameter int SCK_HALF = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done
);

  localparam int K_W   = LEN_W + 2;
  localparam int GAP   = 2 * SCK_HALF;
  localparam int GAP_W = $clog2(GAP + 1);

  qrd_pkg::qrd_state_e st;
  qrd_pkg::qrd_pad_t   pad_q;

  logic [23:0]      addr_q;
  logic [K_W-1:0]   kcnt;
  logic [K_W-1:0]   last_k;
  logic [GAP_W-1:0] gap_cnt;
  logic             run, hold_low, rise_ev, fall_ev;
  logic             stall, in_data, take_nib, accept, last_rise;

  assign stall     = rd_valid && !rd_ready;
  assign run       = (st == qrd_pkg::ST_RUN) || (st == qrd_pkg::ST_TAIL);
  assign hold_low  = stall || (st == qrd_pkg::ST_TAIL);
  assign in_data   = (kcnt >= K_W'(qrd_pkg::QRD_DATA_START));
  assign take_nib  = rise_ev && in_data;
  assign last_rise = rise_ev && (kcnt == last_k);
  assign req_ready = (st == qrd_pkg::ST_IDLE) && !rd_valid;
  assign accept    = req_valid && req_ready;
  assign io_out    = pad_q.dout;
  assign io_oe     = pad_q.oe;

  qrd_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .hold_low (hold_low),
    .sck      (sck),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  qrd_byte_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_nib (take_nib),
    .low_half (kcnt[0]),
    .nib      (io_in),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= qrd_pkg::ST_IDLE;
      cs_n    <= 1'b1;
      pad_q   <= '0;
      addr_q  <= '0;
      kcnt    <= '0;
      last_k  <= '0;
      gap_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        qrd_pkg::ST_IDLE: begin
          if (accept) begin
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              st     <= qrd_pkg::ST_RUN;
              cs_n   <= 1'b0;
              addr_q <= req_addr;
              kcnt   <= '0;
              last_k <= K_W'(qrd_pkg::last_clock(32'(req_len)));
              pad_q  <= qrd_pkg::pad_for_clock(0, req_addr);
            end
          end
        end
        qrd_pkg::ST_RUN: begin
          if (rise_ev) kcnt <= kcnt + 1'b1;
          if (last_rise) st <= qrd_pkg::ST_TAIL;
          if (fall_ev) pad_q <= qrd_pkg::pad_for_clock(32'(kcnt), addr_q);
        end
        qrd_pkg::ST_TAIL: begin
          if (fall_ev) begin
            st      <= qrd_pkg::ST_GAP;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            pad_q   <= '0;
            gap_cnt <= '0;
          end
        end
        default: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_W'(GAP - 1)) st <= qrd_pkg::ST_IDLE;
        end
      endcase
    end
  end

  // R2: only IO0 is driven while the command shifts out
  assert_cmd_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && kcnt < K_W'(qrd_pkg::QRD_ADDR_START)) |-> io_oe == 4'b0001);

  // R4: pads are released once the turnaround clocks are under way
  assert_pads_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && kcnt > K_W'(qrd_pkg::QRD_DUMMY_START)) |-> io_oe == 4'b0000);

  // R6: launch only while the clock is low
  assert_launch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(pad_q));

  // R7: chip select never moves while the clock is high
  assert_cs_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> !sck);

  // R8: the end pulse comes with chip select high
  assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R9: an empty request finishes at once without a frame
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_len == '0) |=> (cs_n && done));

  // R11: no request is taken during a frame
  assert_busy_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

endmodule

// File: tb/qspi_quad_reader_test.sv
module qspi_quad_reader_test;

  localparam int HALF  = 2;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [23:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic             sck, cs_n;
  logic [3:0]       io_out, io_oe, io_in;
  logic [7:0]       rd_data;
  logic             rd_valid, rd_ready, done;

  always #5 clk = ~clk;

  qspi_quad_reader #(.SCK_HALF(HALF), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done)
  );

  int total = 0;
  int bad   = 0;

  // stimulus-owned
  logic [23:0] cur_addr = '0;
  int          mode     = 0;

  // monitor-owned
  int          rises, got, done_cnt, data_bad;
  int          cmd_oe_bad, addr_oe_bad, dummy_oe_bad;
  int          gap_bad, edge_bad, launch_bad, hi_bad, ready_bad;
  int          cs_hi, hi_run;
  logic [7:0]  cap_op, lfsr;
  logic [23:0] cap_addr;
  logic        prev_cs, prev_sck;
  logic [7:0]  prev_pad;

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Flash model and stream consumer, all sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; got = 0; done_cnt = 0; data_bad = 0;
      cmd_oe_bad = 0; addr_oe_bad = 0; dummy_oe_bad = 0;
      gap_bad = 0; edge_bad = 0; launch_bad = 0; hi_bad = 0; ready_bad = 0;
      cs_hi = 1000; hi_run = 0; cap_op = '0; cap_addr = '0; lfsr = 8'h1D;
      prev_cs = 1'b1; prev_sck = 1'b0; prev_pad = '0;
      io_in = 4'h0; rd_ready = 1'b1;
    end else begin
      if (prev_cs && !cs_n) begin
        rises = 0; got = 0; cap_op = '0; cap_addr = '0;
        if (cs_hi < 2 * HALF) gap_bad++;
        if (sck) edge_bad++;
      end
      if (!prev_cs && cs_n && sck) edge_bad++;
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (!cs_n && req_ready) ready_bad++;
      if (sck && {io_oe, io_out} != prev_pad) launch_bad++;
      if (!cs_n && sck && !prev_sck) begin
        if (rises < 8) begin
          cap_op = {cap_op[6:0], io_out[0]};
          if (io_oe !== 4'b0001) cmd_oe_bad++;
        end else if (rises < 14) begin
          cap_addr = {cap_addr[19:0], io_out};
          if (io_oe !== 4'b1111) addr_oe_bad++;
        end else if (io_oe !== 4'b0000) begin
          dummy_oe_bad++;
        end
        rises++;
      end
      if (prev_sck && !sck) begin
        if (hi_run != HALF) hi_bad++;
        if (!cs_n && rises >= 20) begin
          logic [7:0] b;
          b = flash_byte(cap_addr + 24'((rises - 20) / 2));
          io_in = ((rises - 20) % 2 == 0) ? b[7:4] : b[3:0];
        end
      end
      hi_run = sck ? hi_run + 1 : 0;
      if (done) done_cnt++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (mode)
        0:       rd_ready = 1'b1;
        1:       rd_ready = ~rd_ready;
        default: rd_ready = (lfsr[2:0] == 3'b000);
      endcase
      if (rd_valid && rd_ready) begin
        if (rd_data !== flash_byte(cur_addr + 24'(got))) data_bad++;
        got++;
      end
      prev_cs  = cs_n;
      prev_sck = sck;
      prev_pad = {io_oe, io_out};
    end
  end

  task automatic run_frame(input logic [23:0] a, input int n, input int m);
    int d0, bad0, w;
    mode     = m;
    cur_addr = a;
    w = 0;
    while (!req_ready && w < 4000) begin @(negedge clk); w++; end
    check(req_ready == 1'b1, "R11 ready before request", req_ready, 1);
    d0   = done_cnt;
    bad0 = data_bad;
    req_addr  = a;
    req_len   = LEN_W'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(done == 1'b1 && cs_n == 1'b1, "R9 empty request",
            {cs_n, done}, 2'b11);
      @(negedge clk);
      check(cs_n == 1'b1 && done == 1'b0, "R9 no frame after empty",
            {cs_n, done}, 2'b10);
    end else begin
      w = 0;
      while (done_cnt == d0 && w < 4000) begin @(negedge clk); w++; end
      w = 0;
      while (got < n && w < 4000) begin @(negedge clk); w++; end
      check(rises == 20 + 2 * n, "R7 frame clock count", rises, 20 + 2 * n);
      check(cap_op == 8'hEB, "R2 command byte", cap_op, 8'hEB);
      check(cap_addr == a, "R3 address", cap_addr, a);
      check(dummy_oe_bad == 0, "R4 pads released", dummy_oe_bad, 0);
      check(got == n, "R5 byte count", got, n);
      check(data_bad == bad0, "R5 byte values", data_bad - bad0, 0);
      check(done_cnt == d0 + 1, "R8 done pulses", done_cnt - d0, 1);
    end
  endtask

  task automatic run_all();
    run_frame(24'h000000, 1, 0);
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 16; n++) begin
        run_frame(24'h012345 + 24'(n * 97 + m * 4099), n, m);
      end
    end
    run_frame(24'hFFFFFD, 6, 0);
    run_frame(24'hFFFFFF, 3, 2);
    run_frame(24'h800000, 15, 1);
    run_frame(24'h000000, 0, 0);
    run_frame(24'hA5A5A5, 2, 0);
    check(cmd_oe_bad == 0, "R2 command enables", cmd_oe_bad, 0);
    check(addr_oe_bad == 0, "R3 address enables", addr_oe_bad, 0);
    check(launch_bad == 0, "R6 launch while sck high", launch_bad, 0);
    check(hi_bad == 0, "R6 sck high phase", hi_bad, 0);
    check(edge_bad == 0, "R7 cs change with sck high", edge_bad, 0);
    check(gap_bad == 0, "R8 cs high gap", gap_bad, 0);
    check(ready_bad == 0, "R11 ready during frame", ready_bad, 0);
    check(data_bad == 0, "R10 bytes under stalls", data_bad, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 reset cs/sck", {cs_n, sck}, 2'b10);
    check(io_oe == 4'b0000, "R1 reset enables", io_oe, 0);
    check(rd_valid == 1'b0 && done == 1'b0, "R1 reset stream",
          {rd_valid, done}, 0);
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule